// File: doc/BRIEF.md
# Linear Sensor Scan Sequencer

The block is the digital control of a two-section linear photodiode array. The pixels themselves and their analog levels are not modelled. What is modelled is the control state: which pixel drives the output in a given clock, when a section's output stage is enabled, when the integrators are held in reset, and whether each pixel's sample element is tracking its integrator or holding a frozen value.

Each section has a start input and a hold input. When a start is captured, a single token enters a shift register of `PIX_N` stages and walks it one stage per clock. Each stage selects one pixel. When the token reaches the last stage, it appears as the section's serial output.

A captured hold does two things:
- It freezes every pixel of the section.
- It opens an integrator-reset window `RST_CLKS` clocks long.

After the window closes, a pixel goes back to tracking once it has been read.

In chained mode, section 0's serial output is section 1's start, so the two sections read out as one line of `2*PIX_N` pixels. In split mode, each section is started from its own input.

Top module: `lsa_scan_seq`

## Requirements
- R1: After reset, every section is idle: `sel_o`, `aoen_o`, `so_o`, `irst_o` and `viol_o` are all zero, and every bit of `trk_o` is 1 (tracking).
- R2: A section's start sampled high on a rising edge while its token is absent selects that section's pixel 0 (`sel_o` bit `sec*PIX_N + 0`) and raises `aoen_o[sec]` for the next cycle. Each following edge moves the single selected bit up by one pixel.
- R3: `so_o[sec]` is high for exactly the cycle after the `PIX_N`-th edge of a scan, counting the start edge as edge 1. Edge `PIX_N+1` clears it, drops `aoen_o[sec]` and leaves the section's `sel_o` slice all zero.
- R4: A hold sampled high while the section has no token and no open window does two things. It clears every `trk_o` bit of the section, and it raises `irst_o[sec]` for exactly `RST_CLKS` cycles. The reset flag falls on edge `RST_CLKS+1`, counting the hold edge as edge 1.
- R5: Take a section frozen at edge f whose pixel j is read in the cycle after edge s+j. That pixel's `trk_o` bit returns to 1 on edge max(s+j+1, f+RST_CLKS). No pixel returns to tracking while the window has more than one clock left.
- R6: With `chain_i`=1, section 1's start comes from `so_o[0]` and `start_i[1]` is ignored. Section 1's pixel 0 is selected after edge `PIX_N+1`, and `so_o[1]` is high after edge `2*PIX_N`.
- R7: With `chain_i`=0, each section runs from its own `start_i`/`hold_i` pair, and the other section's activity has no effect on it.
- R8: A start sampled while the section's token is in flight does not disturb the running scan. The same holds for a hold sampled while the token or the window is active. Either event sets `viol_o[sec]`, which stays 1 until reset.
- R9: The earliest start accepted after a scan is on edge `PIX_N+2`. A start on edge `PIX_N+1` is ignored and flagged.
- R10: A start with hold low reads the pixels out but leaves `trk_o` and `irst_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_i | input | 1 | 1: chained (section 1 started by section 0's serial output); 0: split |
| start_i | input | 2 | Start pulse per section |
| hold_i | input | 2 | Freeze/reset-window request per section |
| sel_o | output | 2*PIX_N | Pixel select; section s uses bits s*PIX_N and up, one-hot or zero |
| aoen_o | output | 2 | Analog output enable per section (0 = high impedance) |
| so_o | output | 2 | Serial output per section |
| irst_o | output | 2 | Integrator reset active per section |
| trk_o | output | 2*PIX_N | Per-pixel sample state, 1 = tracking, 0 = holding |
| viol_o | output | 2 | Sticky protocol-violation flag per section |

## Verification
Two events fall on the same edge in this block, and the bench provokes both.

The first is edge `RST_CLKS+1` of a frozen scan. The closing reset window releases pixels 0 to `RST_CLKS-1` together on that edge. On the same edge, the pixel just read (index `RST_CLKS-1`) goes through its normal after-read release. The bench checks the full `trk_o` slice on every cycle against the max(read end, window end) rule, which judges the two against each other.

The second collision is a new start arriving on the edge where the token leaves the last stage. Starts are driven on edges `PIX_N+1` and `PIX_N+2`. The bench expects the first to be ignored and flagged, and the second to begin a fresh scan with a fresh freeze.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic {
    SCAN_SPLIT = 1'b0,
    SCAN_CHAIN = 1'b1
  } scan_mode_e;

  localparam int unsigned NSEC = 2;
endpackage

// File: rtl/lsa_token_chain.sv
module lsa_token_chain #(
  parameter int unsigned PIX_N = 640
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [PIX_N-1:0] tok_o,
  output logic             busy_o,
  output logic             so_o
);
  logic acc;

  assign busy_o = |tok_o;
  assign acc    = start_i & ~busy_o;
  assign so_o   = tok_o[PIX_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_o <= '0;
    else         tok_o <= {tok_o[PIX_N-2:0], acc};
  end

  // R2
  tok_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tok_o));

  // R3
  so_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o |=> !so_o);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> !tok_o[0]);
endmodule

// File: rtl/lsa_rst_window.sv
module lsa_rst_window #(
  parameter int unsigned RST_CLKS = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic busy_i,
  output logic act_o,
  output logic rel_ok_o,
  output logic acc_o
);
  localparam int unsigned CW = $clog2(RST_CLKS + 1);

  logic [CW-1:0] cnt_q;

  assign act_o    = (cnt_q != '0);
  assign rel_ok_o = (cnt_q <= CW'(1));
  assign acc_o    = hold_i & ~busy_i & ~act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (acc_o)  cnt_q <= CW'(RST_CLKS);
    else if (act_o)  cnt_q <= cnt_q - CW'(1);
  end

  // R4
  win_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !busy_i && !act_o |=> act_o);

  // R4
  win_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o) |-> $past(hold_i));
endmodule

// File: rtl/lsa_track_ctl.sv
module lsa_track_ctl #(
  parameter int unsigned PIX_N = 640
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frz_i,
  input  logic             rel_ok_i,
  input  logic [PIX_N-1:0] tok_i,
  output logic [PIX_N-1:0] trk_o
);
  logic [PIX_N-1:0] rd_q;
  logic [PIX_N-1:0] rel;

  for (genvar k = 0; k < PIX_N; k++) begin : g_pix
    // read finished (token passed) and window no longer holding it
    assign rel[k] = ~trk_o[k] & (tok_i[k] | rd_q[k]) & rel_ok_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trk_o[k] <= 1'b1;
        rd_q[k]  <= 1'b0;
      end else if (frz_i) begin
        trk_o[k] <= 1'b0;
        rd_q[k]  <= 1'b0;
      end else begin
        if (rel[k])                      trk_o[k] <= 1'b1;
        if (rel[k])                      rd_q[k]  <= 1'b0;
        else if (tok_i[k] && !trk_o[k])  rd_q[k]  <= 1'b1;
      end
    end
  end

  // R5
  no_early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_ok_i && !frz_i |=> ((trk_o & ~$past(trk_o)) == '0));
endmodule

// File: rtl/lsa_section.sv
module lsa_section #(
  parameter int unsigned PIX_N    = 640,
  parameter int unsigned RST_CLKS = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hold_i,
  output logic [PIX_N-1:0] sel_o,
  output logic             aoen_o,
  output logic             so_o,
  output logic             irst_o,
  output logic [PIX_N-1:0] trk_o,
  output logic             viol_o
);
  logic busy, rel_ok, frz;

  lsa_token_chain #(.PIX_N(PIX_N)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .tok_o  (sel_o),
    .busy_o (busy),
    .so_o   (so_o)
  );

  lsa_rst_window #(.RST_CLKS(RST_CLKS)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold_i),
    .busy_i  (busy),
    .act_o   (irst_o),
    .rel_ok_o(rel_ok),
    .acc_o   (frz)
  );

  lsa_track_ctl #(.PIX_N(PIX_N)) u_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frz_i   (frz),
    .rel_ok_i(rel_ok),
    .tok_i   (sel_o),
    .trk_o   (trk_o)
  );

  assign aoen_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_o <= 1'b0;
    else if ((start_i && busy) || (hold_i && !frz)) viol_o <= 1'b1;
  end

  // R8
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
endmodule

// File: rtl/lsa_scan_seq.sv
module lsa_scan_seq
  import lsa_pkg::*;
#(
  parameter int unsigned PIX_N    = 640,
  parameter int unsigned RST_CLKS = 18
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   chain_i,
  input  logic [1:0]             start_i,
  input  logic [1:0]             hold_i,
  output logic [2*PIX_N-1:0]     sel_o,
  output logic [1:0]             aoen_o,
  output logic [1:0]             so_o,
  output logic [1:0]             irst_o,
  output logic [2*PIX_N-1:0]     trk_o,
  output logic [1:0]             viol_o
);
  scan_mode_e       mode;
  logic [NSEC-1:0]  sec_start;

  assign mode = scan_mode_e'(chain_i);

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    if (g == 0) begin : g_head
      assign sec_start[g] = start_i[g];
    end else begin : g_tail
      // chained: upstream serial output is this section's start
      assign sec_start[g] = (mode == SCAN_CHAIN) ? so_o[g-1] : start_i[g];
    end

    lsa_section #(.PIX_N(PIX_N), .RST_CLKS(RST_CLKS)) u_sec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(sec_start[g]),
      .hold_i (hold_i[g]),
      .sel_o  (sel_o[g*PIX_N +: PIX_N]),
      .aoen_o (aoen_o[g]),
      .so_o   (so_o[g]),
      .irst_o (irst_o[g]),
      .trk_o  (trk_o[g*PIX_N +: PIX_N]),
      .viol_o (viol_o[g])
    );
  end

  // R6
  chain_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_i && so_o[0] && !aoen_o[1] |=> sel_o[PIX_N]);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aoen_o[0] |-> (sel_o[PIX_N-1:0] == '0) && !so_o[0]);
endmodule

// File: tb/lsa_scan_seq_bench.sv
module lsa_scan_seq_bench;
  localparam int PIX = 640;
  localparam int RW  = 18;
  localparam int TOT = 2 * PIX;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           chain = 1'b0;
  logic [1:0]     start = '0;
  logic [1:0]     hold = '0;
  logic [TOT-1:0] sel_o, trk_o;
  logic [1:0]     aoen_o, so_o, irst_o, viol_o;

  int n_chk = 0;
  int n_fail = 0;
  int edge_n = 0;

  lsa_scan_seq #(.PIX_N(PIX), .RST_CLKS(RW)) u_lsa_scan_seq (
    .clk_i(clk), .rst_ni(rst_n), .chain_i(chain), .start_i(start),
    .hold_i(hold), .sel_o(sel_o), .aoen_o(aoen_o), .so_o(so_o),
    .irst_o(irst_o), .trk_o(trk_o), .viol_o(viol_o)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    edge_n++;
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = '0; hold = '0; chain = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
    edge_n = 0;
  endtask

  task automatic chk_bit(string req, string what, logic a, logic e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s edge %0d: got %0b exp %0b", req, what, edge_n, a, e);
    end
  endtask

  function automatic int first_set(logic [PIX-1:0] v);
    for (int j = 0; j < PIX; j++) if (v[j]) return j;
    return -1;
  endfunction

  function automatic logic [PIX-1:0] exp_trk(int s, int f, int n);
    logic [PIX-1:0] v;
    for (int j = 0; j < PIX; j++) begin
      int rel;
      if (f < 0)      v[j] = 1'b1;
      else if (s < 0) v[j] = 1'b0;
      else begin
        rel  = (s + j + 1 > f + RW) ? s + j + 1 : f + RW;
        v[j] = (n >= rel);
      end
    end
    return v;
  endfunction

  // s: start edge, f: freeze edge (-1 = none)
  task automatic chk_sec(int sec, int s, int f, string scen);
    int n = edge_n;
    int k;
    logic [PIX-1:0] e_sel, e_trk, a_sel, a_trk;
    logic e_so, e_rst, e_en;
    k = (s >= 0) ? n - s : -1;
    e_sel = '0;
    if (s >= 0 && k >= 0 && k < PIX) e_sel[k] = 1'b1;
    e_en  = |e_sel;
    e_so  = (s >= 0 && k == PIX - 1);
    e_rst = (f >= 0 && n >= f && n - f < RW);
    e_trk = exp_trk(s, f, n);
    a_sel = sel_o[sec*PIX +: PIX];
    a_trk = trk_o[sec*PIX +: PIX];

    n_chk++;
    if (a_sel !== e_sel) begin
      n_fail++;
      $display("FAIL R2 %s sec%0d sel edge %0d: got pixel %0d (%0d set) exp pixel %0d",
               scen, sec, n, first_set(a_sel), $countones(a_sel), first_set(e_sel));
    end
    chk_bit("R3", $sformatf("%s sec%0d aoen", scen, sec), aoen_o[sec], e_en);
    chk_bit("R3", $sformatf("%s sec%0d so", scen, sec), so_o[sec], e_so);
    chk_bit("R4", $sformatf("%s sec%0d irst", scen, sec), irst_o[sec], e_rst);
    n_chk++;
    if (a_trk !== e_trk) begin
      int j;
      j = first_set(a_trk ^ e_trk);
      n_fail++;
      $display("FAIL R5 %s sec%0d trk edge %0d pixel %0d: got %0b exp %0b",
               scen, sec, n, j, a_trk[j], e_trk[j]);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_sec(0, -1, -1, "R1 reset");
    chk_sec(1, -1, -1, "R1 reset");
    chk_bit("R1", "viol0", viol_o[0], 1'b0);
    chk_bit("R1", "viol1", viol_o[1], 1'b0);
  endtask

  task automatic t_single();
    do_reset();
    start = 2'b01; hold = 2'b01;
    tick();
    start = '0; hold = '0;
    chk_sec(0, 1, 1, "single");
    chk_sec(1, -1, -1, "single R7");
    while (edge_n < PIX + 3) begin
      tick();
      chk_sec(0, 1, 1, "single");
      chk_sec(1, -1, -1, "single R7");
    end
    chk_bit("R8", "single viol0", viol_o[0], 1'b0);
  endtask

  task automatic t_chain();
    do_reset();
    chain = 1'b1;
    start = 2'b01; hold = 2'b11;
    tick();
    start = '0; hold = '0;
    chk_sec(0, 1, 1, "chain R6");
    chk_sec(1, 641, 1, "chain R6");
    while (edge_n < 2 * PIX + 3) begin
      start[1] = (edge_n == 4);   // must be ignored in chained mode
      tick();
      start[1] = 1'b0;
      chk_sec(0, 1, 1, "chain R6");
      chk_sec(1, PIX + 1, 1, "chain R6");
    end
    chk_bit("R6", "chain viol1", viol_o[1], 1'b0);
  endtask

  task automatic t_split_both();
    do_reset();
    start = 2'b01; hold = 2'b01;
    tick();
    start = '0; hold = '0;
    while (edge_n < PIX + 8) begin
      if (edge_n == 4) begin start = 2'b10; hold = 2'b10; end
      tick();
      start = '0; hold = '0;
      chk_sec(0, 1, 1, "split R7");
      chk_sec(1, (edge_n >= 5) ? 5 : -1, (edge_n >= 5) ? 5 : -1, "split R7");
    end
  endtask

  task automatic t_busy_start();
    do_reset();
    start = 2'b01; hold = 2'b01;
    tick();
    start = '0; hold = '0;
    while (edge_n < PIX + 3) begin
      if (edge_n == 99) begin start = 2'b01; hold = 2'b01; end
      tick();
      start = '0; hold = '0;
      chk_sec(0, 1, 1, "busy R8");
      if (edge_n == 99)  chk_bit("R8", "viol before late start", viol_o[0], 1'b0);
      if (edge_n == 100) chk_bit("R8", "viol after late start", viol_o[0], 1'b1);
    end
    chk_bit("R8", "viol sticky", viol_o[0], 1'b1);
    chk_bit("R8", "other section viol", viol_o[1], 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    start = 2'b01; hold = 2'b01;
    tick();
    start = '0; hold = '0;
    while (edge_n < 2 * PIX + 4) begin
      if (edge_n == PIX || edge_n == PIX + 1) begin start = 2'b01; hold = 2'b01; end
      tick();
      start = '0; hold = '0;
      if (edge_n <= PIX + 1) chk_sec(0, 1, 1, "restart R9");
      else                   chk_sec(0, PIX + 2, PIX + 2, "restart R9");
      if (edge_n == PIX + 1) chk_bit("R9", "start on last edge flagged", viol_o[0], 1'b1);
    end
  endtask

  task automatic t_no_hold();
    do_reset();
    start = 2'b01;
    tick();
    start = '0;
    chk_sec(0, 1, -1, "nohold R10");
    while (edge_n < PIX + 3) begin
      tick();
      chk_sec(0, 1, -1, "nohold R10");
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_single();
    t_chain();
    t_split_both();
    t_busy_start();
    t_restart();
    t_no_hold();
    finish_run();
  end
endmodule